// File: doc/BRIEF.md
# Supply-Guarded Strobe Register Port

This block is the slave side of a register/RAM array driven by an asynchronous bus with active-low strobes. The bus has a chip select, a read strobe, a write strobe, a 15-bit address and an 8-bit data path. The data path is split into `data_in`, `data_out` and a pad enable `data_oe`, and the pad ring joins them into one bidirectional pin. A two-stage synchronizer brings all bus inputs into the system clock domain. The port classifies each clock's strobe levels as idle, read or write. On a read it drives the addressed word. On a write it stores the word present on the bus when the write closes.

A supply supervisor sits in front of the bus logic and watches two comparator flags, `supply_good` (above the upper threshold) and `supply_low` (below the protect threshold). While it is protecting, the port ignores every bus input: it drives nothing, stores nothing and leaves the array unchanged. Protection ends only after `supply_good` has stayed high, with `supply_low` clear, for `HOLD_CYCLES` clocks in a row. Any break in that interval restarts the count. The block also comes out of reset protected.

The array holds `2**MEM_AW` words. Addresses with any bit set above that window read as zero, and writes to them are discarded.

Top module: `strobe_reg_port`

## Requirements
- R1: After reset the port is protected with `data_oe` low, and it answers no bus cycle until the hold-off interval of R9 has elapsed.
- R2: A read is serviced while `ce_n`=0, `oe_n`=0 and `we_n`=1. In that case `data_oe` is 1 and `data_out` carries the addressed word. With `ce_n` high or `oe_n` high, `data_oe` stays 0.
- R3: A write is open while `ce_n` and `we_n` are both 0. It opens when the later of the two falls and closes when the earlier of the two rises, whichever strobe that is. A `we_n` pulse while `ce_n` is high stores nothing.
- R4: The word stored is the `data_in` value, at the address present on the bus, just before the write closes. Earlier values seen during the same write are discarded.
- R5: If `we_n` falls while a read is being driven, `data_oe` drops. The write that follows is serviced normally.
- R6: Address bits `[MEM_AW-1:0]` select the word. If any higher address bit is 1, a read drives all-zero data and a write changes no word.
- R7: While `supply_low` is 1, or until recovery completes, no read drives the bus and no write is stored. All array contents are kept unchanged through the protected period.
- R8: If protection begins while a write is open, that write is aborted and stores nothing, even if service returns before the write closes.
- R9: Service resumes only after `supply_good`=1 and `supply_low`=0 have held for `HOLD_CYCLES` consecutive clocks. A drop of `supply_good` or a rise of `supply_low` during that interval restarts the count.
- R10: Once in service, a fall of `supply_good` alone (with `supply_low` still 0) does not end service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Read strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W (15) | Word address |
| data_in | input | DATA_W (8) | Write data from the pad |
| data_out | output | DATA_W (8) | Read data to the pad |
| data_oe | output | 1 | Pad output enable for `data_out` |
| supply_good | input | 1 | Comparator flag: supply above the upper threshold |
| supply_low | input | 1 | Comparator flag: supply below the protect threshold |

## Verification
The hardest state to reach from the ports is a write aborted by R8 in which service comes back before the write closes. The stimulus opens a write and pulses `supply_low`. It then keeps both strobes low for longer than the whole hold-off, and closes the write only after service has returned. A read-back then shows that the word is unchanged. The restart of the hold-off under R9 is handled in a similar way. A read is held open across a `supply_good` glitch that lands partway through recovery. `data_oe` is then sampled at a point that is already past the hold-off if counted from the first rise, but not yet past it if counted from the last rise.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        SUP_PROT    = 2'd0,
        SUP_RECOVER = 2'd1,
        SUP_RUN     = 2'd2
    } sup_state_e;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

    // Write wins over read: an open write never also counts as a read.
    function automatic cyc_kind_e classify(strobe_t s);
        if (!s.ce_n && !s.we_n) return CYC_WRITE;
        if (!s.ce_n && !s.oe_n) return CYC_READ;
        return CYC_IDLE;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_supervisor.sv
module srp_supervisor
    import srp_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic good_s,
    input  logic low_s,
    output logic in_service
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    sup_state_e    st;
    logic [CW-1:0] cnt;
    logic          healthy;

    assign healthy = good_s && !low_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SUP_PROT;
            cnt <= '0;
        end else begin
            case (st)
                SUP_PROT: begin
                    cnt <= '0;
                    if (healthy) st <= SUP_RECOVER;
                end
                SUP_RECOVER: begin
                    if (!healthy) begin
                        st  <= SUP_PROT;
                        cnt <= '0;
                    end else if (cnt == LAST) begin
                        st  <= SUP_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SUP_RUN: begin
                    cnt <= '0;
                    if (low_s) st <= SUP_PROT;
                end
                default: begin
                    st  <= SUP_PROT;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign in_service = (st == SUP_RUN);

    // R7
    low_forces_prot_chk: assert property (@(posedge clk) disable iff (rst)
        low_s |=> !in_service);

    // R9
    entry_needs_health_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_service) |-> ($past(good_s) && !$past(low_s)));

    // R9
    hold_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(HOLD_CYCLES));

    // R10
    good_drop_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        (in_service && !low_s) |=> in_service);
endmodule

// File: rtl/srp_cycle.sv
module srp_cycle
    import srp_pkg::*;
#(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       stb,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          in_service,
    output logic          rd_active,
    output logic          wr_commit,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    cyc_kind_e     kind;
    logic          wr_now;
    logic          wr_prev;
    logic          abort_q;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    assign kind      = classify(stb);
    assign wr_now    = (kind == CYC_WRITE);
    assign rd_active = (kind == CYC_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev   <= 1'b0;
            abort_q   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now) begin
                hold_addr <= addr;
                hold_data <= data;
            end
            if (!wr_now)          abort_q <= 1'b0;
            else if (!in_service) abort_q <= 1'b1;
        end
    end

    assign wr_commit = wr_prev && !wr_now && !abort_q && in_service;
    assign wr_addr   = hold_addr;
    assign wr_data   = hold_data;

    // R8
    prot_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_now && !in_service) |=> !wr_commit);

    // R3
    commit_on_close_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (stb.ce_n || stb.we_n));
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i))) mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_reg_port.sv
module strobe_reg_port
    import srp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 8,
    parameter int SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              supply_good,
    input  logic              supply_low
);
    localparam int BUS_W = ADDR_W + DATA_W;

    strobe_t           stb_raw;
    strobe_t           stb_s;
    logic [2:0]        stb_vec_s;
    logic [1:0]        flags_s;
    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              in_service;
    logic              rd_active;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rdata;
    logic              rd_in_range;
    logic              wr_in_range;

    assign stb_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_stb_sync (
        .clk(clk), .rst(rst), .d(stb_raw), .q(stb_vec_s)
    );
    assign stb_s = strobe_t'(stb_vec_s);

    srp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_flag_sync (
        .clk(clk), .rst(rst), .d({supply_good, supply_low}), .q(flags_s)
    );

    srp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst(rst), .d({addr, data_in}), .q(bus_s)
    );
    assign {addr_s, data_s} = bus_s;

    srp_supervisor #(.HOLD_CYCLES(HOLD_CYCLES)) u_sup (
        .clk(clk), .rst(rst), .good_s(flags_s[1]), .low_s(flags_s[0]),
        .in_service(in_service)
    );

    srp_cycle #(.AW(ADDR_W), .DW(DATA_W)) u_cyc (
        .clk(clk), .rst(rst), .stb(stb_s), .addr(addr_s), .data(data_s),
        .in_service(in_service), .rd_active(rd_active), .wr_commit(wr_commit),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    if (MEM_AW < ADDR_W) begin : g_window
        assign rd_in_range = ~|addr_s[ADDR_W-1:MEM_AW];
        assign wr_in_range = ~|wr_addr[ADDR_W-1:MEM_AW];
    end else begin : g_full
        assign rd_in_range = 1'b1;
        assign wr_in_range = 1'b1;
    end

    srp_regfile #(.DW(DATA_W), .AW(MEM_AW)) u_rf (
        .clk(clk), .we(wr_commit && wr_in_range), .waddr(wr_addr[MEM_AW-1:0]),
        .wdata(wr_data), .raddr(addr_s[MEM_AW-1:0]), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end else begin
            data_oe  <= in_service && rd_active;
            data_out <= (in_service && rd_active && rd_in_range) ? rdata : '0;
        end
    end

    // R5
    we_kills_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !stb_s.we_n |=> !data_oe);

    // R2
    drive_origin_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> $past(!stb_s.ce_n && !stb_s.oe_n && stb_s.we_n));

    // R7
    prot_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !in_service |=> !data_oe);

    // R6
    high_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ($past(rd_in_range) || (data_out == '0)));
endmodule

// File: tb/strobe_reg_port_test.sv
module strobe_reg_port_test;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int MAW = 4;
    localparam int HOLD = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          doe;
    logic          good = 1'b1, low = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [1 << MAW];

    always #2 clk = ~clk;

    strobe_reg_port #(.ADDR_W(AW), .DATA_W(DW), .MEM_AW(MAW), .SYNC_STAGES(2),
                      .HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .data_in(din), .data_out(dout), .data_oe(doe),
        .supply_good(good), .supply_low(low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int round);
        return DW'((a * 29 + round * 71 + 3) & 8'hFF);
    endfunction

    // order[0]: 0 = ce_n falls first, 1 = we_n falls first
    // order[1]: 0 = ce_n rises first, 1 = we_n rises first
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int order, input bit late, input logic [DW-1:0] dl);
        addr = a; din = d; oe_n = 1'b1;
        tick(2);
        if (order[0] == 0) ce_n = 1'b0; else we_n = 1'b0;
        tick(4);
        if (order[0] == 0) we_n = 1'b0; else ce_n = 1'b0;
        tick(4);
        if (late) begin din = dl; tick(4); end
        if (order[1] == 0) ce_n = 1'b1; else we_n = 1'b1;
        tick(4);
        ce_n = 1'b1; we_n = 1'b1;
        tick(4);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic e);
        addr = a;
        tick(1);
        ce_n = 1'b0; oe_n = 1'b0;
        tick(6);
        v = dout; e = doe;
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);
    endtask

    task automatic expect_word(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        logic [DW-1:0] v;
        logic e;
        do_read(a, v, e);
        check(e == 1'b1, req, int'(e), 1);
        check(v == exp, req, int'(v), int'(exp));
    endtask

    initial begin
        logic [DW-1:0] v;
        logic e;

        // R1: reset state
        tick(5);
        check(doe == 1'b0, "R1 reset", int'(doe), 0);
        rst = 1'b0;
        addr = '0; ce_n = 1'b0; oe_n = 1'b0;
        tick(20);
        check(doe == 1'b0, "R1 hold-off after reset", int'(doe), 0);
        tick(40);
        check(doe == 1'b1, "R9 service after hold-off", int'(doe), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);

        // R3 R4: sweep of all words with every strobe ordering, two rounds
        for (int r = 0; r < 2; r++) begin
            for (int a = 0; a < (1 << MAW); a++) begin
                model[a] = pat(a, r);
                do_write(AW'(a), (r == 1) ? ~pat(a, r) : pat(a, r), a % 4, r == 1, pat(a, r));
            end
            for (int a = 0; a < (1 << MAW); a++)
                expect_word(AW'(a), model[a], (r == 1) ? "R4 value at close" : "R3 strobe orders");
        end

        // R3: we_n pulse with ce_n high stores nothing
        addr = AW'(5); din = 8'hC3;
        tick(2); we_n = 1'b0; tick(6); we_n = 1'b1; tick(4);
        expect_word(AW'(5), model[5], "R3 lone we_n");

        // R2: ce_n low alone does not drive
        addr = AW'(5); ce_n = 1'b0; tick(6);
        check(doe == 1'b0, "R2 oe_n high", int'(doe), 0);
        ce_n = 1'b1; oe_n = 1'b0; tick(6);
        check(doe == 1'b0, "R2 ce_n high", int'(doe), 0);
        oe_n = 1'b1; tick(4);

        // R6: addresses with bits above the window
        begin
            logic [AW-1:0] hi [3];
            hi[0] = AW'(16'h0010); hi[1] = AW'(16'h0100); hi[2] = AW'(16'h4000);
            for (int k = 0; k < 3; k++) begin
                do_write(hi[k] | AW'(3), 8'hEE, k, 1'b0, 8'h00);
                expect_word(AW'(3), model[3], "R6 high write discarded");
                expect_word(hi[k] | AW'(3), 8'h00, "R6 high read zero");
            end
        end

        // R5: we_n falling during a driven read
        addr = AW'(7); din = 8'h5A; ce_n = 1'b0; oe_n = 1'b0;
        tick(6);
        check(doe == 1'b1 && dout == model[7], "R5 read before we_n", int'(dout), int'(model[7]));
        we_n = 1'b0;
        tick(5);
        check(doe == 1'b0, "R5 drive released", int'(doe), 0);
        we_n = 1'b1;
        tick(6);
        model[7] = 8'h5A;
        check(doe == 1'b1 && dout == 8'h5A, "R5 write then read", int'(dout), 8'h5A);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);

        // R10: supply_good drop alone keeps service
        good = 1'b0;
        tick(20);
        do_write(AW'(2), 8'h3C, 0, 1'b0, 8'h00);
        model[2] = 8'h3C;
        expect_word(AW'(2), 8'h3C, "R10 still in service");
        good = 1'b1;
        tick(4);

        // R7: protected period ignores the bus and keeps contents
        low = 1'b1;
        tick(6);
        do_read(AW'(2), v, e);
        check(e == 1'b0, "R7 no drive when protected", int'(e), 0);
        do_write(AW'(2), 8'h99, 3, 1'b0, 8'h00);
        do_write(AW'(11), 8'h77, 1, 1'b0, 8'h00);
        low = 1'b0;
        tick(HOLD + 20);
        expect_word(AW'(2), model[2], "R7 contents kept");
        expect_word(AW'(11), model[11], "R7 contents kept");

        // R8: write open across a supply dip, closed after service returns
        addr = AW'(9); din = 8'hA5; oe_n = 1'b1;
        tick(2);
        ce_n = 1'b0; we_n = 1'b0;
        tick(6);
        low = 1'b1;
        tick(6);
        low = 1'b0;
        tick(HOLD + 20);
        ce_n = 1'b1; we_n = 1'b1;
        tick(4);
        expect_word(AW'(9), model[9], "R8 aborted write");

        // R9: hold-off restarts on a supply_good glitch
        addr = AW'(9); ce_n = 1'b0; oe_n = 1'b0;
        tick(6);
        check(doe == 1'b1, "R9 serving before dip", int'(doe), 1);
        low = 1'b1;
        tick(6);
        check(doe == 1'b0, "R7 dip stops drive", int'(doe), 0);
        low = 1'b0;
        tick(30);
        good = 1'b0;
        tick(3);
        good = 1'b1;
        tick(30);
        check(doe == 1'b0, "R9 count restarted", int'(doe), 0);
        tick(25);
        check(doe == 1'b1 && dout == model[9], "R9 service after restart", int'(dout), int'(model[9]));
        ce_n = 1'b1; oe_n = 1'b1;
        tick(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule